// File: doc/BRIEF.md
# Run-Time Configurable Decimating FIR Post-Filter

This block smooths and thins out a stream of signed samples, such as the output of a frequency discriminator. Every accepted input sample goes into a circular history of 63 entries. After each group of D accepted inputs, a single multiply-accumulate engine steps through the taps and produces one filtered output sample. D is the decimation factor. The tap count, the decimation factor and the coefficient folding mode are all read from configuration inputs at run time.

When symmetric coefficients are selected, the filter stores and uses only the first half of the coefficient set. Each mirrored pair of history samples is first added (even symmetry) or subtracted (odd symmetry). The pair result then goes through one multiply, so a sweep takes about half as many cycles. Coefficients live in a small register bank that is written through an address/data port. The accumulator keeps full precision, and the output is a fixed bit slice of it, truncated with no rounding.

The caller keeps the input rate low enough that the sweep finishes before the next input arrives. The sweep length L is the tap count when folding is off, and half the tap count rounded up when folding is on. So the caller leaves at least L+1 idle cycles after each input that completes a group. Configuration is held steady while samples flow.

Top module: `pfd_decim_fir`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `out_data` are 0. Reset also clears the sample history, the coefficient bank and the decimation count, so a stream that starts after reset sees zero history and zero coefficients until new values are written.
- R2: `cfg_taps` sets the tap count N directly for codes 1..63. Code 0 acts as N = 1.
- R3: With `cfg_asym` = 1, output = sum over k = 0..N-1 of c[k]·x[n-k]. Here c[k] is the value last written to coefficient address k, and x[n] is the newest sample.
- R4: With `cfg_asym` = 0 and `cfg_even` = 1, only addresses 0..L-1 are used, with L = ceil(N/2). Each term is c[k]·(x[n-k] + x[n-(N-1-k)]). When N is odd, the centre term k = (N-1)/2 is c[k]·x[n-k] alone.
- R5: With `cfg_asym` = 0 and `cfg_even` = 0, each term is c[k]·(x[n-k] − x[n-(N-1-k)]) for k = 0..L-1. When N is odd, the centre term is again c[k]·x[n-k] alone.
- R6: `cfg_dec` codes 1..7 give D = 1..7, and code 0 gives D = 8. Exactly one output is produced per D accepted inputs. The first output follows the D-th input after reset.
- R7: `out_valid` is a single-cycle pulse. When the input that completes a group is sampled at edge e, `out_valid` is high in the cycle after edge e+L, where L = N with folding off and ceil(N/2) with folding on.
- R8: The accumulator never overflows, even with full-scale samples and coefficients. `out_data` is bits [30:15] of the signed accumulator, so an out-of-range result wraps in that slice.
- R9: The history is a 63-entry ring. After more than 63 inputs, a 63-tap filter uses exactly the 63 most recent samples across the ring's wrap point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_taps | input | 6 | Tap-count code (0 acts as 1) |
| cfg_dec | input | 3 | Decimation code (0 means 8) |
| cfg_asym | input | 1 | 1: plain coefficients, 0: folded symmetric coefficients |
| cfg_even | input | 1 | Folded mode: 1 adds mirrored pairs, 0 subtracts them |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient write address (0..62) |
| coef_data | input | 16 | Signed coefficient value |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Signed filtered sample (accumulator slice) |

## Verification
The bench builds the block with its defaults: 16-bit samples and coefficients, a 63-entry history and bank, a 3-bit decimation code, and an output slice starting at bit 15. These sizes put the full 63-tap sweep, the wrap of the 63-entry ring, and the decimate-by-8 code within reach. They also allow a full-scale run with every sample and coefficient at −32768, which drives the accumulator near its top bit. That run shows the slice wrapping while the sum itself stays exact.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // width of the counters that hold tap counts and sweep positions
    localparam int CNT_W = 8;

    // how a sweep step combines the two history samples it reads
    typedef enum logic [1:0] {
        FOLD_PASS = 2'd0,
        FOLD_SUM  = 2'd1,
        FOLD_DIFF = 2'd2
    } fold_e;

    // configuration captured when a sweep begins
    typedef struct packed {
        logic             asym;
        logic             even;
        logic [CNT_W-1:0] ntaps;
        logic [CNT_W-1:0] len;
    } sweep_cfg_t;

    // decimation code to factor: zero stands for the largest power of two
    function automatic int decim_factor(input int code, input int code_w);
        return (code == 0) ? (1 << code_w) : code;
    endfunction

    // tap-count code to tap count: zero is promoted to one tap
    function automatic int eff_taps(input int code);
        return (code == 0) ? 1 : code;
    endfunction

    // number of multiply-accumulate steps in one sweep
    function automatic int sweep_len(input int ntaps, input logic asym);
        return asym ? ntaps : (ntaps + 1) / 2;
    endfunction

    // ring position of a sample that is 'age' inputs older than 'base'
    function automatic int ring_index(input int base, input int age, input int depth);
        return (base >= age) ? (base - age) : (base + depth - age);
    endfunction

endpackage

// File: rtl/pfd_coef_bank.sv
module pfd_coef_bank
    import pfd_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int DEPTH  = 63,
    parameter int AW     = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [AW-1:0]            raddr,
    output logic signed [COEF_W-1:0] rdata
);

    logic signed [COEF_W-1:0] bank_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= '0;
            end
        end else if (we && (int'(waddr) < DEPTH)) begin
            bank_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) begin
            rdata = bank_q[raddr];
        end
    end

endmodule

// File: rtl/pfd_hist_ring.sv
module pfd_hist_ring
    import pfd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 63,
    parameter int PW     = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    output logic [PW-1:0]            wr_ptr,
    input  logic [PW-1:0]            rd_base,
    input  logic [PW-1:0]            age_a,
    input  logic [PW-1:0]            age_b,
    output logic signed [DATA_W-1:0] rd_a,
    output logic signed [DATA_W-1:0] rd_b
);

    logic signed [DATA_W-1:0] ring_q [DEPTH];
    logic [PW-1:0]            ptr_q;
    logic [PW-1:0]            idx_a;
    logic [PW-1:0]            idx_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ring_q[i] <= '0;
            end
        end else if (wr_en) begin
            ring_q[ptr_q] <= wr_data;
            ptr_q         <= (int'(ptr_q) == DEPTH - 1) ? '0 : ptr_q + 1'b1;
        end
    end

    assign wr_ptr = ptr_q;

    always_comb begin
        idx_a = PW'(ring_index(int'(rd_base), int'(age_a), DEPTH));
        idx_b = PW'(ring_index(int'(rd_base), int'(age_b), DEPTH));
        rd_a  = '0;
        rd_b  = '0;
        if (int'(idx_a) < DEPTH) rd_a = ring_q[idx_a];
        if (int'(idx_b) < DEPTH) rd_b = ring_q[idx_b];
    end

endmodule

// File: rtl/pfd_decim_ctl.sv
module pfd_decim_ctl
    import pfd_pkg::*;
#(
    parameter int DEC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DEC_W-1:0] cfg_dec,
    output logic             group_done
);

    logic [DEC_W-1:0] cnt_q;
    logic             last_in_group;

    always_comb begin
        last_in_group = (int'(cnt_q) == decim_factor(int'(cfg_dec), DEC_W) - 1);
        group_done    = in_valid && last_in_group;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= last_in_group ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pfd_mac_seq.sv
module pfd_mac_seq
    import pfd_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int TAP_W   = 6,
    parameter int PW      = 6,
    parameter int ACC_W   = 39,
    parameter int OUT_W   = 16,
    parameter int OUT_LSB = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [TAP_W-1:0]         cfg_taps,
    input  logic                     cfg_asym,
    input  logic                     cfg_even,
    input  logic [PW-1:0]            newest_ptr,
    output logic [PW-1:0]            base_ptr,
    output logic [PW-1:0]            age_a,
    output logic [PW-1:0]            age_b,
    input  logic signed [DATA_W-1:0] samp_a,
    input  logic signed [DATA_W-1:0] samp_b,
    output logic [TAP_W-1:0]         coef_addr,
    input  logic signed [COEF_W-1:0] coef_val,
    output logic                     busy,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);

    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;

    sweep_cfg_t               cfg_q;
    sweep_cfg_t               cfg_d;
    logic [CNT_W-1:0]         step_q;
    logic [PW-1:0]            base_q;
    logic                     busy_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_next;
    logic                     ovalid_q;
    logic signed [OUT_W-1:0]  odata_q;

    fold_e                    fold;
    logic signed [PRE_W-1:0]  ext_a;
    logic signed [PRE_W-1:0]  ext_b;
    logic signed [PRE_W-1:0]  pre_sum;
    logic signed [PROD_W-1:0] product;
    logic                     last_step;

    // configuration captured at the start of a sweep
    always_comb begin
        cfg_d.asym  = cfg_asym;
        cfg_d.even  = cfg_even;
        cfg_d.ntaps = CNT_W'(eff_taps(int'(cfg_taps)));
        cfg_d.len   = CNT_W'(sweep_len(eff_taps(int'(cfg_taps)), cfg_asym));
    end

    // history ages and coefficient address for the current step
    always_comb begin
        age_a     = PW'(step_q);
        age_b     = PW'(cfg_q.ntaps - 1'b1 - step_q);
        coef_addr = TAP_W'(step_q);
        base_ptr  = base_q;
    end

    // pre-add selection, multiply and accumulate
    always_comb begin
        if (cfg_q.asym || (age_a == age_b)) begin
            fold = FOLD_PASS;
        end else if (cfg_q.even) begin
            fold = FOLD_SUM;
        end else begin
            fold = FOLD_DIFF;
        end

        ext_a = PRE_W'(samp_a);
        ext_b = PRE_W'(samp_b);
        unique case (fold)
            FOLD_SUM:  pre_sum = ext_a + ext_b;
            FOLD_DIFF: pre_sum = ext_a - ext_b;
            default:   pre_sum = ext_a;
        endcase

        product   = PROD_W'(pre_sum) * PROD_W'(coef_val);
        acc_next  = acc_q + ACC_W'(product);
        last_step = (step_q == cfg_q.len - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            step_q   <= '0;
            base_q   <= '0;
            busy_q   <= 1'b0;
            acc_q    <= '0;
            ovalid_q <= 1'b0;
            odata_q  <= '0;
        end else begin
            ovalid_q <= 1'b0;
            if (busy_q) begin
                acc_q  <= acc_next;
                step_q <= step_q + 1'b1;
                if (last_step) begin
                    busy_q   <= 1'b0;
                    ovalid_q <= 1'b1;
                    odata_q  <= acc_next[OUT_LSB +: OUT_W];
                end
            end else if (start) begin
                busy_q <= 1'b1;
                step_q <= '0;
                acc_q  <= '0;
                base_q <= newest_ptr;
                cfg_q  <= cfg_d;
            end
        end
    end

    assign busy      = busy_q;
    assign out_valid = ovalid_q;
    assign out_data  = odata_q;

endmodule

// File: rtl/pfd_decim_fir.sv
module pfd_decim_fir
    import pfd_pkg::*;
#(
    parameter int  DATA_W   = 16,
    parameter int  COEF_W   = 16,
    parameter int  MAX_TAPS = 63,
    parameter int  DEC_W    = 3,
    parameter int  OUT_W    = 16,
    parameter int  OUT_LSB  = 15,
    localparam int TAP_W    = $clog2(MAX_TAPS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TAP_W-1:0]         cfg_taps,
    input  logic [DEC_W-1:0]         cfg_dec,
    input  logic                     cfg_asym,
    input  logic                     cfg_even,
    input  logic                     coef_we,
    input  logic [TAP_W-1:0]         coef_addr,
    input  logic signed [COEF_W-1:0] coef_data,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);

    localparam int PW    = $clog2(MAX_TAPS);
    localparam int ACC_W = DATA_W + 1 + COEF_W + $clog2(MAX_TAPS);

    logic                     group_done;
    logic                     busy;
    logic [PW-1:0]            newest_ptr;
    logic [PW-1:0]            base_ptr;
    logic [PW-1:0]            age_a;
    logic [PW-1:0]            age_b;
    logic signed [DATA_W-1:0] samp_a;
    logic signed [DATA_W-1:0] samp_b;
    logic [TAP_W-1:0]         rd_addr;
    logic signed [COEF_W-1:0] rd_coef;

    pfd_decim_ctl #(.DEC_W(DEC_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cfg_dec    (cfg_dec),
        .group_done (group_done)
    );

    pfd_hist_ring #(.DATA_W(DATA_W), .DEPTH(MAX_TAPS), .PW(PW)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid),
        .wr_data (in_data),
        .wr_ptr  (newest_ptr),
        .rd_base (base_ptr),
        .age_a   (age_a),
        .age_b   (age_b),
        .rd_a    (samp_a),
        .rd_b    (samp_b)
    );

    pfd_coef_bank #(.COEF_W(COEF_W), .DEPTH(MAX_TAPS), .AW(TAP_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (rd_addr),
        .rdata (rd_coef)
    );

    pfd_mac_seq #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .TAP_W  (TAP_W),
        .PW     (PW),
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W),
        .OUT_LSB(OUT_LSB)
    ) u_mac (
        .clk        (clk),
        .rst        (rst),
        .start      (group_done),
        .cfg_taps   (cfg_taps),
        .cfg_asym   (cfg_asym),
        .cfg_even   (cfg_even),
        .newest_ptr (newest_ptr),
        .base_ptr   (base_ptr),
        .age_a      (age_a),
        .age_b      (age_b),
        .samp_a     (samp_a),
        .samp_b     (samp_b),
        .coef_addr  (rd_addr),
        .coef_val   (rd_coef),
        .busy       (busy),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

endmodule

// File: rtl/pfd_decim_fir_chk.sv
module pfd_decim_fir_chk
    import pfd_pkg::*;
#(
    parameter int TAP_W = 6,
    parameter int DEC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [TAP_W-1:0] cfg_taps,
    input logic [DEC_W-1:0] cfg_dec,
    input logic             cfg_asym,
    input logic             in_valid,
    input logic             out_valid
);

    logic [CNT_W-1:0] grp_cnt;
    logic [CNT_W-1:0] lat_cnt;
    logic             armed;
    logic [CNT_W-1:0] prior_in_group;
    logic             trigger;
    int               exp_dec;
    int               exp_len;

    always_comb begin
        exp_dec        = decim_factor(int'(cfg_dec), DEC_W);
        exp_len        = sweep_len(eff_taps(int'(cfg_taps)), cfg_asym);
        prior_in_group = out_valid ? '0 : grp_cnt;
        trigger        = in_valid && (int'(prior_in_group) == exp_dec - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_cnt <= '0;
            lat_cnt <= '0;
            armed   <= 1'b0;
        end else begin
            if (out_valid) begin
                grp_cnt <= in_valid ? CNT_W'(1) : '0;
            end else if (in_valid) begin
                grp_cnt <= grp_cnt + 1'b1;
            end

            if (trigger) begin
                armed   <= 1'b1;
                lat_cnt <= CNT_W'(1);
            end else begin
                if (out_valid) armed <= 1'b0;
                if (armed && (lat_cnt != '1)) lat_cnt <= lat_cnt + 1'b1;
            end
        end
    end

    // R1: reset leaves the output strobe low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R7: the output strobe never lasts more than one cycle
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R6: each output closes a group of exactly D accepted inputs
    assert_group_size_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(grp_cnt) == exp_dec));

    // R7: the output appears L+1 cycles after the group's last input
    assert_sweep_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (armed && (int'(lat_cnt) == exp_len + 1)));

endmodule

bind pfd_decim_fir pfd_decim_fir_chk #(.TAP_W(TAP_W), .DEC_W(DEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_taps  (cfg_taps),
    .cfg_dec   (cfg_dec),
    .cfg_asym  (cfg_asym),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/tb_pfd_decim_fir.sv
`timescale 1ns/1ps
module tb_pfd_decim_fir;

    localparam int DATA_W  = 16;
    localparam int COEF_W  = 16;
    localparam int NTAP    = 63;
    localparam int OUT_LSB = 15;
    localparam int OUT_W   = 16;
    localparam int GAP     = 68;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [5:0]               cfg_taps = '0;
    logic [2:0]               cfg_dec = '0;
    logic                     cfg_asym = 1'b1;
    logic                     cfg_even = 1'b1;
    logic                     coef_we = 1'b0;
    logic [5:0]               coef_addr = '0;
    logic signed [COEF_W-1:0] coef_data = '0;
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic                     out_valid;
    logic signed [OUT_W-1:0]  out_data;

    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    int unsigned seed = 32'h1234_5678;

    int m_hist [NTAP];
    int m_coef [NTAP];
    int m_taps;
    int m_dec;
    int m_len;
    bit m_asym;
    bit m_even;
    int m_count;

    always #4 clk = ~clk;

    pfd_decim_fir dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_taps  (cfg_taps),
        .cfg_dec   (cfg_dec),
        .cfg_asym  (cfg_asym),
        .cfg_even  (cfg_even),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'($signed(seed[31:16]));
    endfunction

    function automatic logic [OUT_W-1:0] model_out();
        longint      acc = 0;
        logic [63:0] bits;
        if (m_asym) begin
            for (int k = 0; k < m_taps; k++) acc += longint'(m_coef[k]) * longint'(m_hist[k]);
        end else begin
            for (int k = 0; k < m_len; k++) begin
                int a = m_hist[k];
                int b = m_hist[m_taps - 1 - k];
                int s;
                if (k == m_taps - 1 - k) s = a;
                else if (m_even) s = a + b;
                else s = a - b;
                acc += longint'(m_coef[k]) * longint'(s);
            end
        end
        bits = acc;
        return bits[OUT_LSB +: OUT_W];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NTAP; i++) begin m_hist[i] = 0; m_coef[i] = 0; end
        m_count = 0;
        total++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            bad++;
            $display("FAIL R1 after reset: out_valid=%0b out_data=%0d expected 0/0", out_valid, out_data);
        end
    endtask

    task automatic set_cfg(input int taps_code, input int dec_code, input bit asym, input bit even);
        int n;
        cfg_taps = 6'(taps_code); cfg_dec = 3'(dec_code); cfg_asym = asym; cfg_even = even;
        n = (taps_code == 0) ? 1 : taps_code;
        m_taps = n; m_asym = asym; m_even = even;
        m_dec = (dec_code == 0) ? 8 : dec_code;
        m_len = asym ? n : (n + 1) / 2;
    endtask

    // mode 0: pseudo-random, mode 1: every entry equals cval
    task automatic load_coefs(input int mode, input int cval);
        for (int a = 0; a < NTAP; a++) begin
            int v = (mode == 0) ? (next_rand() >>> 1) : cval;
            coef_we = 1'b1; coef_addr = 6'(a); coef_data = COEF_W'(v);
            m_coef[a] = v;
            @(posedge clk); @(negedge clk);
        end
        coef_we = 1'b0;
    endtask

    // mode 0: pseudo-random, mode 1: constant sval, mode 2: small ramp
    task automatic run_stream(input string tag, input int n_in, input int mode, input int sval);
        for (int i = 0; i < n_in; i++) begin
            int v;
            bit trig;
            logic [OUT_W-1:0] expv;
            int seen_j;
            int seen_n;
            logic [OUT_W-1:0] seen_d;
            if (mode == 0) v = next_rand();
            else if (mode == 1) v = sval;
            else v = (i * 37) % 200 - 100;
            for (int k = NTAP - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
            m_hist[0] = v;
            m_count++;
            trig = (m_count % m_dec) == 0;
            expv = trig ? model_out() : '0;
            in_valid = 1'b1; in_data = DATA_W'(v);
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            seen_j = -1; seen_n = 0; seen_d = '0;
            for (int j = 0; j < GAP; j++) begin
                if (out_valid === 1'b1) begin
                    seen_n++;
                    if (seen_j < 0) begin seen_j = j; seen_d = out_data; end
                end
                @(negedge clk);
            end
            total++;
            if (trig) begin
                if (seen_n != 1 || seen_j != m_len || seen_d !== expv) begin
                    bad++;
                    $display("FAIL %s input %0d: pulses=%0d at=%0d data=%0d expected pulses=1 at=%0d data=%0d",
                             tag, i, seen_n, seen_j, $signed(seen_d), m_len, $signed(expv));
                end
            end else if (seen_n != 0) begin
                bad++;
                $display("FAIL %s R6 input %0d: pulses=%0d expected 0", tag, i, seen_n);
            end
        end
    endtask

    task automatic t_reset_state();
        do_reset();  // R1
    endtask

    task automatic t_asym_basic();
        do_reset(); set_cfg(5, 1, 1'b1, 1'b0); load_coefs(0, 0);
        run_stream("R3 asym 5 taps", 12, 0, 0);
    endtask

    task automatic t_tap_zero();
        do_reset(); set_cfg(0, 1, 1'b1, 1'b0); load_coefs(0, 0);
        run_stream("R2 tap code 0", 6, 0, 0);
        set_cfg(63, 1, 1'b1, 1'b0);
        run_stream("R2 tap code 63", 4, 0, 0);
    endtask

    task automatic t_sym_even();
        do_reset(); set_cfg(7, 2, 1'b0, 1'b1); load_coefs(0, 0);
        run_stream("R4 even 7 taps", 16, 0, 0);
        do_reset(); set_cfg(8, 3, 1'b0, 1'b1); load_coefs(0, 0);
        run_stream("R4 even 8 taps", 18, 2, 0);
    endtask

    task automatic t_sym_odd();
        do_reset(); set_cfg(6, 1, 1'b0, 1'b0); load_coefs(0, 0);
        run_stream("R5 odd 6 taps", 12, 0, 0);
        do_reset(); set_cfg(5, 1, 1'b0, 1'b0); load_coefs(0, 0);
        run_stream("R5 odd 5 taps", 12, 0, 0);
    endtask

    task automatic t_dec_codes();
        do_reset(); set_cfg(4, 0, 1'b1, 1'b0); load_coefs(0, 0);
        run_stream("R6 dec code 0", 24, 0, 0);
        do_reset(); set_cfg(3, 7, 1'b1, 1'b0); load_coefs(0, 0);
        run_stream("R6 dec code 7", 14, 0, 0);
    endtask

    task automatic t_ring_wrap();
        do_reset(); set_cfg(63, 7, 1'b1, 1'b0); load_coefs(0, 0);
        run_stream("R9 asym 63 wrap", 150, 0, 0);
        do_reset(); set_cfg(63, 1, 1'b0, 1'b1); load_coefs(0, 0);
        run_stream("R9 even 63 wrap", 80, 0, 0);
    endtask

    task automatic t_full_scale();
        do_reset(); set_cfg(63, 1, 1'b1, 1'b0); load_coefs(1, -32768);
        run_stream("R8 full scale asym", 66, 1, -32768);
        do_reset(); set_cfg(63, 1, 1'b0, 1'b1); load_coefs(1, -32768);
        run_stream("R8 full scale even", 66, 1, -32768);
        do_reset(); set_cfg(62, 1, 1'b1, 1'b0); load_coefs(1, 32767);
        run_stream("R8 full scale pos", 64, 1, 32767);
    endtask

    task automatic t_reset_clears();
        // coefficients were written before this reset; R1 says they are cleared
        do_reset(); set_cfg(3, 1, 1'b1, 1'b0);
        run_stream("R1 bank cleared", 4, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_asym_basic();
        t_tap_zero();
        t_sym_even();
        t_sym_odd();
        t_dec_codes();
        t_ring_wrap();
        t_full_scale();
        t_reset_clears();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule